// File: doc/BRIEF.md
# Receive Buffer Ring Writer

This block sits behind a receive path and places the bytes of incoming Ethernet frames into memory. Memory is split into fixed 128-byte buffers. Each buffer belongs to one entry of a circular ring of two-word descriptors. The first word of an entry carries the buffer address in bits 31:2, an ownership flag in bit 0 and an end-of-ring flag in bit 1. The second word receives a status summary from the block.

Frames arrive one byte per valid cycle and are marked with start, end and broadcast flags. Before the first byte goes into a buffer, the block looks at the entry's ownership flag. An entry still held by the receiver is refused: the frame is cut short and an overrun pulse is raised. A buffer is closed when it has taken 128 bytes or when the frame ends. On closing, the block writes the entry back with its ownership flag set, together with a status word. It then moves to the next entry, or back to the ring base if the entry carried the end-of-ring flag. A frame may continue across any number of entries, including across the ring's return to entry 0.

The descriptor memory is read combinationally through an address/word pair. Buffer bytes leave on a byte-write port, and descriptor updates leave on a two-word write port. All of these act in the same cycle as the byte that causes them.

Top module: `rxr_ring_writer`

## Requirements
- R1: Each stored byte is written to the byte address (first descriptor word with bits 1:0 cleared) plus its offset within the buffer, in arrival order, one write per accepted byte.
- R2: A buffer takes exactly 128 bytes. The byte that fills it closes the entry, and the next byte of the frame goes to offset 0 of the next entry's buffer. A frame of exactly 128 bytes uses one entry.
- R3: On the cycle of the byte that closes an entry, the block writes that entry back with the first word unchanged except bit 0 set to 1. This write never happens without a byte write in the same cycle.
- R4: The status word written on close has bit 14 set if the entry holds the frame's first byte and bit 15 set if it holds the last byte. Bits 11:0 hold the total frame length on the last entry and 0 on other entries. Bit 31 is set on the last entry when the broadcast flag accompanies the end byte. All other bits are 0.
- R5: The entry read address is ring base + 8 × index. After a close, the index goes up by one, or returns to 0 when bit 1 of the closed entry's first word is set. This also applies partway through a frame.
- R6: When a byte needs a new buffer and the entry's bit 0 is 1, the block pulses overrun in that cycle and stores nothing. It drops the rest of the frame until the next start byte, and the index does not move.
- R7: A base-load cycle takes the new ring base, sets the index to 0, ignores any byte present in that cycle and abandons a frame in progress. The abandoned frame's remaining bytes are not stored.
- R8: A frame whose start byte arrives while enable is low is ignored entirely. Dropping enable after a frame has started does not affect that frame.
- R9: After reset the ring base and index are 0 and no write or overrun is signalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Accept new frames |
| base_load | input | 1 | Load ring base and restart at entry 0 |
| base_addr | input | AW | Ring base byte address |
| in_valid | input | 1 | Byte present this cycle |
| in_byte | input | 8 | Frame byte |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| in_bcast | input | 1 | Frame is broadcast (sampled with the end byte) |
| desc_rd_addr | output | AW | Address of the current entry's first word |
| desc_rd_word | input | 32 | First word of the current entry (combinational read) |
| data_we | output | 1 | Buffer byte write strobe |
| data_addr | output | AW | Buffer byte address |
| data_byte | output | 8 | Buffer byte value |
| desc_we | output | 1 | Entry write-back strobe |
| desc_wr_addr | output | AW | Address of the entry written back |
| desc_wr_word0 | output | 32 | First word written back (ownership set) |
| desc_wr_status | output | 32 | Status word written back |
| overrun | output | 1 | Entry still owned when a buffer was needed |

## Verification
The hardest case to reach is an ownership refusal in the middle of a frame. In that case earlier entries of the frame are already closed without an end flag, and the rest of the frame must leave no trace. The bench produces it by handing back only one entry before sending a 200-byte frame, so the second buffer request meets an owned entry. A second hard case is a frame that crosses the end-of-ring entry. This is reached by first sending a frame that leaves the index one past the base, then sending a 400-byte frame. A reference model in the bench follows every byte and compares all write ports on each clock.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
   localparam int unsigned OWN_BIT        = 0;
   localparam int unsigned RING_END_BIT   = 1;
   localparam int unsigned FIRST_BIT      = 14;
   localparam int unsigned LAST_BIT       = 15;
   localparam int unsigned BCAST_BIT      = 31;
   localparam int unsigned DESC_WORD_W    = 32;
   localparam int unsigned STRIDE_LOG2    = 3;
endpackage

// File: rtl/rxr_ring_index.sv
module rxr_ring_index #(
   parameter int unsigned AW    = 32,
   parameter int unsigned IDX_W = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] load_addr,
   input  logic          adv,
   input  logic          ring_end,
   output logic [AW-1:0] desc_addr
);
   import rxr_pkg::*;

   localparam int unsigned PAD_W  = AW - IDX_W - STRIDE_LOG2;
   localparam logic [AW-1:0] STRIDE = AW'(1) << STRIDE_LOG2;

   logic [AW-1:0]    base_q;
   logic [IDX_W-1:0] idx_q;

   assign desc_addr = base_q + {{PAD_W{1'b0}}, idx_q, {STRIDE_LOG2{1'b0}}};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q <= '0;
         idx_q  <= '0;
      end else if (load) begin
         base_q <= load_addr;
         idx_q  <= '0;
      end else if (adv) begin
         idx_q  <= ring_end ? '0 : idx_q + 1'b1;
      end
   end

   p_base_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> desc_addr == $past(load_addr));

   p_return_to_base_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && ring_end && !load) |=> desc_addr == base_q);

   p_next_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !ring_end && !load && idx_q != '1) |=> desc_addr == $past(desc_addr) + STRIDE);
endmodule

// File: rtl/rxr_frame_track.sv
module rxr_frame_track #(
   parameter int unsigned BUF_BYTES = 128,
   parameter int unsigned LEN_W     = 12,
   localparam int unsigned OFF_W    = $clog2(BUF_BYTES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             abandon,
   input  logic             byte_v,
   input  logic             sof,
   input  logic             eof,
   input  logic             en,
   input  logic             owned,
   output logic             store,
   output logic             ovr,
   output logic             close,
   output logic             is_first,
   output logic [OFF_W-1:0] offset,
   output logic [LEN_W-1:0] length_now
);
   localparam logic [OFF_W-1:0] OFF_LAST = OFF_W'(BUF_BYTES - 1);

   logic             live_q;
   logic             first_q;
   logic [OFF_W-1:0] off_q;
   logic [LEN_W-1:0] len_q;

   logic new_frame;
   logic take;
   logic need_buf;

   always_comb begin
      new_frame  = byte_v && sof && !abandon;
      take       = byte_v && !abandon && (sof ? en : live_q);
      need_buf   = new_frame || (off_q == '0);
      ovr        = take && need_buf && owned;
      store      = take && !ovr;
      offset     = need_buf ? '0 : off_q;
      length_now = (new_frame ? '0 : len_q) + 1'b1;
      is_first   = new_frame || first_q;
      close      = store && (eof || offset == OFF_LAST);
   end

   always_ff @(posedge clk) begin
      if (!rst_n || abandon) begin
         live_q  <= 1'b0;
         first_q <= 1'b0;
         off_q   <= '0;
         len_q   <= '0;
      end else if (byte_v) begin
         if ((new_frame && !en) || ovr) begin
            live_q  <= 1'b0;
            first_q <= 1'b0;
            off_q   <= '0;
         end else if (store) begin
            live_q  <= !eof;
            first_q <= close ? 1'b0 : is_first;
            off_q   <= close ? '0 : offset + 1'b1;
            len_q   <= length_now;
         end
      end
   end
endmodule

// File: rtl/rxr_status_fmt.sv
module rxr_status_fmt #(
   parameter int unsigned LEN_W     = 12,
   parameter bit          LEN_EVERY = 1'b0
) (
   input  logic             first,
   input  logic             last,
   input  logic             bcast,
   input  logic [LEN_W-1:0] len,
   output logic [31:0]      status
);
   import rxr_pkg::*;

   logic [LEN_W-1:0] len_field;

   generate
      if (LEN_EVERY) begin : g_len_all
         assign len_field = len;
      end else begin : g_len_last
         assign len_field = last ? len : '0;
      end
   endgenerate

   always_comb begin
      status              = '0;
      status[LEN_W-1:0]   = len_field;
      status[FIRST_BIT]   = first;
      status[LAST_BIT]    = last;
      status[BCAST_BIT]   = last && bcast;
   end
endmodule

// File: rtl/rxr_ring_writer.sv
module rxr_ring_writer #(
   parameter int unsigned AW        = 32,
   parameter int unsigned IDX_W     = 8,
   parameter int unsigned BUF_BYTES = 128,
   parameter int unsigned LEN_W     = 12,
   parameter bit          LEN_EVERY = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          base_load,
   input  logic [AW-1:0] base_addr,
   input  logic          in_valid,
   input  logic [7:0]    in_byte,
   input  logic          in_sof,
   input  logic          in_eof,
   input  logic          in_bcast,
   output logic [AW-1:0] desc_rd_addr,
   input  logic [31:0]   desc_rd_word,
   output logic          data_we,
   output logic [AW-1:0] data_addr,
   output logic [7:0]    data_byte,
   output logic          desc_we,
   output logic [AW-1:0] desc_wr_addr,
   output logic [31:0]   desc_wr_word0,
   output logic [31:0]   desc_wr_status,
   output logic          overrun
);
   import rxr_pkg::*;

   localparam int unsigned OFF_W = $clog2(BUF_BYTES);

   generate
      if (BUF_BYTES < 4 || (BUF_BYTES & (BUF_BYTES - 1)) != 0) begin : g_bad_buf
         $error("BUF_BYTES must be a power of two of at least 4");
      end
      if (LEN_W > FIRST_BIT || (1 << LEN_W) < BUF_BYTES) begin : g_bad_len
         $error("LEN_W must fit below the first-buffer flag and cover one buffer");
      end
      if (AW > DESC_WORD_W || AW < IDX_W + STRIDE_LOG2 + 1) begin : g_bad_aw
         $error("AW must fit the descriptor word and the ring index");
      end
   endgenerate

   logic             store, ovr, close, is_first;
   logic [OFF_W-1:0] offset;
   logic [LEN_W-1:0] length_now;
   logic [AW-1:0]    buf_start;

   rxr_ring_index #(.AW(AW), .IDX_W(IDX_W)) u_index (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (base_load),
      .load_addr (base_addr),
      .adv       (close),
      .ring_end  (desc_rd_word[RING_END_BIT]),
      .desc_addr (desc_rd_addr)
   );

   rxr_frame_track #(.BUF_BYTES(BUF_BYTES), .LEN_W(LEN_W)) u_track (
      .clk        (clk),
      .rst_n      (rst_n),
      .abandon    (base_load),
      .byte_v     (in_valid),
      .sof        (in_sof),
      .eof        (in_eof),
      .en         (en),
      .owned      (desc_rd_word[OWN_BIT]),
      .store      (store),
      .ovr        (ovr),
      .close      (close),
      .is_first   (is_first),
      .offset     (offset),
      .length_now (length_now)
   );

   rxr_status_fmt #(.LEN_W(LEN_W), .LEN_EVERY(LEN_EVERY)) u_status (
      .first  (is_first),
      .last   (in_eof),
      .bcast  (in_bcast),
      .len    (length_now),
      .status (desc_wr_status)
   );

   assign buf_start     = {desc_rd_word[AW-1:2], 2'b00};
   assign data_we       = store;
   assign data_addr     = buf_start + {{(AW-OFF_W){1'b0}}, offset};
   assign data_byte     = in_byte;
   assign desc_we       = close;
   assign desc_wr_addr  = desc_rd_addr;
   assign desc_wr_word0 = desc_rd_word | 32'(1 << OWN_BIT);
   assign overrun       = ovr;

   p_close_with_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
      desc_we |-> data_we);

   p_drop_after_overrun_r6: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |=> (!data_we || in_sof));

   p_sequential_bytes_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (data_we && !desc_we) |=> (!data_we || in_sof || data_addr == $past(data_addr) + 1'b1));

   p_no_store_on_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
      base_load |-> (!data_we && !desc_we && !overrun));
endmodule

// File: tb/sim_rxr_ring_writer.sv
module sim_rxr_ring_writer;
   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] RING = 32'h100;
   localparam logic [31:0] BUFS = 32'h1000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en = 1'b1;
   logic        base_load = 1'b0;
   logic [31:0] base_addr = '0;
   logic        in_valid = 1'b0;
   logic [7:0]  in_byte = '0;
   logic        in_sof = 1'b0, in_eof = 1'b0, in_bcast = 1'b0;
   logic [31:0] desc_rd_addr, desc_rd_word;
   logic        data_we, desc_we, overrun;
   logic [31:0] data_addr, desc_wr_addr, desc_wr_word0, desc_wr_status;
   logic [7:0]  data_byte;

   logic [31:0] dw0 [4];
   logic [31:0] dw1 [4];
   logic [3:0]  clr_req = '0;

   int n_chk = 0, n_fail = 0, cnt_we = 0, cnt_ovr = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rxr_ring_writer u0 (
      .clk(clk), .rst_n(rst_n), .en(en), .base_load(base_load), .base_addr(base_addr),
      .in_valid(in_valid), .in_byte(in_byte), .in_sof(in_sof), .in_eof(in_eof),
      .in_bcast(in_bcast), .desc_rd_addr(desc_rd_addr), .desc_rd_word(desc_rd_word),
      .data_we(data_we), .data_addr(data_addr), .data_byte(data_byte),
      .desc_we(desc_we), .desc_wr_addr(desc_wr_addr), .desc_wr_word0(desc_wr_word0),
      .desc_wr_status(desc_wr_status), .overrun(overrun)
   );

   // descriptor memory: 4 entries, entry 3 ends the ring; unknown addresses read as owned
   always_comb begin
      desc_rd_word = 32'h1;
      for (int k = 0; k < 4; k++)
         if (desc_rd_addr == RING + 32'(k * 8)) desc_rd_word = dw0[k];
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < 4; k++) begin
            dw0[k] <= BUFS + 32'(k * 128) + ((k == 3) ? 32'h2 : 32'h0);
            dw1[k] <= '0;
         end
      end else begin
         for (int k = 0; k < 4; k++) begin
            if (clr_req[k]) dw0[k][0] <= 1'b0;
            if (desc_we && desc_wr_addr == RING + 32'(k * 8)) begin
               dw0[k] <= desc_wr_word0;
               dw1[k] <= desc_wr_status;
            end
         end
      end
   end

   function automatic void chk(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endfunction

   function automatic void chkv(input string tag, input longint act, input longint exp);
      chk(act == exp, tag, act, exp);
   endfunction

   // behavioural reference model, compared every clock
   int m_base = 0, m_idx = 0, m_off = 0, m_len = 0;
   bit m_live = 0, m_first = 0;

   always @(negedge clk) begin
      if (!done) begin
         if (!rst_n) begin
            m_base = 0; m_idx = 0; m_off = 0; m_len = 0; m_live = 0; m_first = 0;
            chkv("R9 data_we in reset", data_we, 0);
            chkv("R9 desc_we in reset", desc_we, 0);
            chkv("R9 overrun in reset", overrun, 0);
         end else begin
            bit byt, nf, take, opn, ov, st, cl, fst;
            int offs, len;
            logic [31:0] w, stat;
            byt  = in_valid && !base_load;
            nf   = byt && in_sof;
            take = byt && (in_sof ? en : m_live);
            w    = (m_idx < 4) ? dw0[m_idx] : 32'h1;
            opn  = nf || (m_off == 0);
            ov   = take && opn && w[0];
            st   = take && !ov;
            offs = opn ? 0 : m_off;
            len  = (nf ? 0 : m_len) + 1;
            fst  = nf || m_first;
            cl   = st && (in_eof || offs == 127);
            stat = (in_eof && in_bcast ? 32'h8000_0000 : 0) | (in_eof ? 32'h8000 : 0)
                 | (fst ? 32'h4000 : 0) | (in_eof ? 32'(len) : 0);
            chkv("R5 read address", desc_rd_addr, m_base + 8 * m_idx);
            chkv("R6 overrun", overrun, ov);
            chkv("R1 byte strobe", data_we, st);
            if (st) begin
               chkv("R1 R2 byte address", data_addr, (w & 32'hFFFF_FFFC) + offs);
               chkv("R1 byte value", data_byte, in_byte);
            end
            chkv("R3 entry strobe", desc_we, cl);
            if (cl) begin
               chkv("R5 entry address", desc_wr_addr, m_base + 8 * m_idx);
               chkv("R3 ownership word", desc_wr_word0, w | 32'h1);
               chkv("R4 status word", desc_wr_status, stat);
            end
            if (data_we) cnt_we++;
            if (overrun) cnt_ovr++;
            if (base_load) begin
               m_base = int'(base_addr); m_idx = 0; m_off = 0; m_len = 0; m_live = 0; m_first = 0;
            end else if (in_valid) begin
               if ((nf && !en) || ov) begin
                  m_live = 0; m_off = 0; m_first = 0;
               end else if (st) begin
                  m_live = !in_eof; m_first = cl ? 0 : fst;
                  m_off = cl ? 0 : offs + 1; m_len = len;
                  if (cl) m_idx = w[1] ? 0 : m_idx + 1;
               end
            end
         end
      end
   end

   task automatic send(input int n, input bit bc, input bit with_sof, input bit with_eof,
                       input bit gap, input int drop_at);
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #1;
         if (i == drop_at) en = 1'b0;
         in_valid = 1'b1;
         in_byte  = 8'(i * 7 + 3);
         in_sof   = with_sof && (i == 0);
         in_eof   = with_eof && (i == n - 1);
         in_bcast = bc && in_eof;
         if (gap && (i % 5 == 4)) begin
            @(posedge clk); #1;
            in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_bcast = 1'b0;
         end
      end
      @(posedge clk); #1;
      in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_bcast = 1'b0;
   endtask

   task automatic give_back(input logic [3:0] mask);
      @(posedge clk); #1; clr_req = mask;
      @(posedge clk); #1; clr_req = '0;
   endtask

   task automatic load_base(input logic [31:0] a);
      @(posedge clk); #1; base_load = 1'b1; base_addr = a;
      @(posedge clk); #1; base_load = 1'b0;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #4;
      chkv("R9 reset read address", desc_rd_addr, 0);
      @(posedge clk); #1; rst_n = 1'b1;
      load_base(RING);
      chkv("R7 base loaded", desc_rd_addr, RING);

      send(60, 1, 1, 1, 0, -1);
      chkv("R4 single-buffer broadcast status", dw1[0], 32'h8000_C03C);
      chkv("R3 entry 0 owned", dw0[0], BUFS | 32'h1);

      send(300, 0, 1, 1, 1, -1);
      chkv("R2 R4 first of three", dw1[1], 32'h4000);
      chkv("R2 R4 middle of three", dw1[2], 32'h0);
      chkv("R2 R4 last of three", dw1[3], 32'h812C);
      chkv("R5 back to base", desc_rd_addr, RING);

      give_back(4'hF);
      send(128, 0, 1, 1, 0, -1);
      chkv("R2 exactly one buffer", dw1[0], 32'hC080);
      chkv("R2 one entry consumed", desc_rd_addr, RING + 8);

      give_back(4'hF);
      send(400, 0, 1, 1, 0, -1);
      chkv("R5 wrap mid-frame first", dw1[1], 32'h4000);
      chkv("R5 wrap mid-frame end", dw1[0], 32'h8190);
      chkv("R5 index after wrap", desc_rd_addr, RING + 8);

      cnt_we = 0; cnt_ovr = 0;
      send(50, 0, 1, 1, 0, -1);
      chkv("R6 owned at start pulses", cnt_ovr, 1);
      chkv("R6 owned at start stores nothing", cnt_we, 0);
      chkv("R6 index held", desc_rd_addr, RING + 8);

      give_back(4'b0010);
      cnt_we = 0; cnt_ovr = 0;
      send(200, 0, 1, 1, 0, -1);
      chkv("R6 mid-frame stores one buffer", cnt_we, 128);
      chkv("R6 mid-frame pulse", cnt_ovr, 1);
      chkv("R6 mid-frame index", desc_rd_addr, RING + 16);

      give_back(4'hF);
      en = 1'b0;
      cnt_we = 0;
      send(60, 0, 1, 1, 0, -1);
      chkv("R8 disabled frame ignored", cnt_we, 0);
      chkv("R8 index unchanged", desc_rd_addr, RING + 16);
      en = 1'b1;
      cnt_we = 0;
      send(100, 0, 1, 1, 0, 10);
      en = 1'b1;
      chkv("R8 enable drop mid-frame", cnt_we, 100);
      chkv("R8 frame complete", dw1[2], 32'hC064);

      send(50, 0, 1, 0, 0, -1);
      load_base(RING);
      cnt_we = 0;
      send(30, 0, 0, 1, 0, -1);
      chkv("R7 abandoned frame dropped", cnt_we, 0);
      chkv("R7 index reset", desc_rd_addr, RING);

      send(10, 0, 1, 1, 0, -1);
      chkv("R1 R4 frame after reload", dw1[0], 32'hC00A);

      repeat (3) @(posedge clk);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_fail++;
         $display("FAIL R9 watchdog: actual 0x1 expected 0x0");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule